// File: doc/BRIEF.md
# Pointer-Selected Register Bank with Interrupt Context Swap

This block is the register bank of a small processor core that has no fixed program counter and no stack pointer. Sixteen 16-bit general registers sit behind two 4-bit pointers. The program pointer names the register used to fetch opcodes and inline operands. The index pointer names the register that addresses memory operands. Changing the program pointer is the whole of a subroutine jump or a coroutine switch. No call or return operation exists.

A four-state machine steps the block through machine cycles of eight clocks each. The states are FETCH (opcode fetch through the program register), EXEC (the decoded command), DMA (one transfer through register 0) and INTR (interrupt entry). FETCH always moves to EXEC. EXEC, DMA and INTR each move to DMA if a transfer is requested, otherwise to INTR if an interrupt is wanted and enabled, otherwise to FETCH. Taking an interrupt packs both pointers into an 8-bit save register, forces the pointers to registers 1 and 2, and masks further interrupts. A return command undoes this. The decoder outside the block presents one command per EXEC cycle and reads the 16-bit address and its kind back from the block.

Top module: `regptr_bank`

## Requirements
- R1: After reset, the program pointer is 0, register 0 is 0, interrupts are enabled, and the first machine cycle is a FETCH that drives address 0 with kind PROG (kind codes: 0 NONE, 1 PROG, 2 DATA, 3 DMA).
- R2: A FETCH cycle drives the register named by the program pointer, with kind PROG. That register holds its value plus one afterwards.
- R3: Command SETP (code 1) makes the register given on `reg_i` the program register. The following FETCH addresses through that register.
- R4: Command SETX (code 2) selects the index register. Command MEMX (code 7) drives that register with kind DATA and leaves it unchanged.
- R5: LDLO (code 3) replaces bits 7:0 of register `reg_i` with `data_i`. LDHI (code 4) replaces bits 15:8. INC (code 5) adds one to the whole 16 bits, with the carry crossing the byte boundary.
- R6: IMM (code 6) drives the program register with kind PROG and increments it, so consecutive inline operands get consecutive addresses.
- R7: Every machine cycle lasts 8 clocks, and its address and kind hold for all 8. Commands NOP (0) and the pointer commands drive address 0 with kind NONE.
- R8: Interrupt entry is a full INTR cycle with address 0 and kind NONE. It saves the program pointer in the upper nibble and the index pointer in the lower nibble of the save register, sets the pointers to 1 and 2, and disables interrupts. The next FETCH addresses through register 1.
- R9: While interrupts are disabled, a request held high causes no further INTR cycle.
- R10: RET (code 8) reloads the program pointer from the save register's upper nibble and the index pointer from its lower nibble, and re-enables interrupts from the next boundary on.
- R11: A request seen in any cycle other than INTR, including one that falls while interrupts are disabled, is held pending and is taken once interrupts are enabled again, even if the input has since dropped.
- R12: A DMA cycle drives register 0 with kind DMA and increments register 0 afterwards.
- R13: A DMA request wins over a simultaneous interrupt. Both are granted only at the end of an EXEC, DMA or INTR cycle, never between a FETCH and its EXEC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 4 | Command code, held for the whole EXEC cycle |
| reg_i | input | 4 | Register number used by the command |
| data_i | input | 8 | Byte for LDLO and LDHI |
| irq_i | input | 1 | Level-sensitive interrupt request |
| dma_req_i | input | 1 | Request for one DMA transfer |
| addr_o | output | 16 | Memory address of the current machine cycle |
| kind_o | output | 2 | Address kind: 0 NONE, 1 PROG, 2 DATA, 3 DMA |

## Verification
Interrupt entry after a SETP or a RET in the same instruction is exercised. A design that saved the stale pointers would later return to the wrong register. A request held high through the handler is checked for re-entry, which a missing mask would show as an endless run of INTR cycles. A short pulse while masked is checked to see that it is still taken after RET, which a design without a pending latch would lose. DMA and an interrupt are raised together to confirm the DMA cycle comes first. INC is run on 0x00FF to catch a carry that stops at the byte boundary.

// File: rtl/regptr_pkg.sv
package regptr_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_DMA   = 2'd2,
        ST_INTR  = 2'd3
    } state_e;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_SETP = 4'd1,
        CMD_SETX = 4'd2,
        CMD_LDLO = 4'd3,
        CMD_LDHI = 4'd4,
        CMD_INC  = 4'd5,
        CMD_IMM  = 4'd6,
        CMD_MEMX = 4'd7,
        CMD_RET  = 4'd8
    } cmd_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'd0,
        KIND_PROG = 2'd1,
        KIND_DATA = 2'd2,
        KIND_DMA  = 2'd3
    } kind_e;

    localparam int P_ON_INT = 1;
    localparam int X_ON_INT = 2;

endpackage

// File: rtl/regptr_file.sv
module regptr_file #(
    parameter int NREG = 16,
    parameter int AW   = 16,
    parameter int NRD  = 4,
    localparam int PW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [PW-1:0]           wr_idx,
    input  logic [AW-1:0]           wr_val,
    input  logic [NRD-1:0][PW-1:0]  rd_idx,
    output logic [NRD-1:0][AW-1:0]  rd_val
);

    logic [AW-1:0] mem [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == 0) begin : g_dma_ptr
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (we && wr_idx == PW'(g))
                    mem[g] <= wr_val;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (we && wr_idx == PW'(g))
                    mem[g] <= wr_val;
            end
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_val[k] = mem[rd_idx[k]];
    end

endmodule

// File: rtl/regptr_seq.sv
module regptr_seq
    import regptr_pkg::*;
#(
    parameter int CYC = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   dma_req,
    input  logic   int_want,
    output state_e state,
    output logic   last,
    output logic   going_int
);

    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    logic [CW-1:0] phase_q;
    state_e        state_q;
    state_e        state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (last)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    always_comb begin
        last    = (phase_q == CW'(CYC - 1));
        state_d = state_q;
        if (last) begin
            unique case (state_q)
                ST_FETCH: state_d = ST_EXEC;
                ST_EXEC, ST_DMA, ST_INTR: begin
                    if (dma_req)
                        state_d = ST_DMA;
                    else if (int_want)
                        state_d = ST_INTR;
                    else
                        state_d = ST_FETCH;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_FETCH;
        else
            state_q <= state_d;
    end

    always_comb begin
        state     = state_q;
        going_int = last && (state_d == ST_INTR);
    end

endmodule

// File: rtl/regptr_ptrs.sv
module regptr_ptrs
    import regptr_pkg::*;
#(
    parameter int PW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  state_e        state,
    input  logic          last,
    input  logic          going_int,
    input  cmd_e          cmd,
    input  logic [PW-1:0] reg_sel,
    input  logic          irq,
    output logic [PW-1:0] p_ptr,
    output logic [PW-1:0] x_ptr,
    output logic [2*PW-1:0] t_reg,
    output logic          ie,
    output logic          int_want
);

    logic [PW-1:0]   p_d, x_d;
    logic [2*PW-1:0] t_d;
    logic            ie_d, pend_q, pend_d;
    logic            exec_end;

    always_comb begin
        exec_end = last && (state == ST_EXEC);
        p_d  = p_ptr;
        x_d  = x_ptr;
        t_d  = t_reg;
        ie_d = ie;
        if (exec_end) begin
            case (cmd)
                CMD_SETP: p_d = reg_sel;
                CMD_SETX: x_d = reg_sel;
                CMD_RET: begin
                    p_d  = t_reg[2*PW-1:PW];
                    x_d  = t_reg[PW-1:0];
                    ie_d = 1'b1;
                end
                default: ;
            endcase
        end
        if (going_int) begin
            t_d  = {p_d, x_d};
            p_d  = PW'(P_ON_INT);
            x_d  = PW'(X_ON_INT);
            ie_d = 1'b0;
        end
        if (going_int)
            pend_d = 1'b0;
        else if (state != ST_INTR && irq)
            pend_d = 1'b1;
        else
            pend_d = pend_q;
        int_want = ie && (irq || pend_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ptr  <= '0;
            x_ptr  <= '0;
            t_reg  <= '0;
            ie     <= 1'b1;
            pend_q <= 1'b0;
        end else begin
            p_ptr  <= p_d;
            x_ptr  <= x_d;
            t_reg  <= t_d;
            ie     <= ie_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/regptr_bank.sv
module regptr_bank
    import regptr_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = 16,
    parameter int DW   = 8,
    parameter int CYC  = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    cmd_i,
    input  logic [PW-1:0] reg_i,
    input  logic [DW-1:0] data_i,
    input  logic          irq_i,
    input  logic          dma_req_i,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    kind_o
);

    localparam int NRD = 4;

    cmd_e            cmd;
    state_e          st;
    logic            last, going_int, int_want, ie;
    logic [PW-1:0]   p_ptr, x_ptr;
    logic [2*PW-1:0] t_reg;

    logic [NRD-1:0][PW-1:0] rd_idx;
    logic [NRD-1:0][AW-1:0] rd_val;
    logic                   we;
    logic [PW-1:0]          wr_idx;
    logic [AW-1:0]          wr_val;
    kind_e                  kind;

    assign cmd = cmd_e'(cmd_i);

    regptr_seq #(.CYC(CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req_i), .int_want(int_want),
        .state(st), .last(last), .going_int(going_int)
    );

    regptr_ptrs #(.PW(PW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .state(st), .last(last), .going_int(going_int),
        .cmd(cmd), .reg_sel(reg_i), .irq(irq_i),
        .p_ptr(p_ptr), .x_ptr(x_ptr), .t_reg(t_reg), .ie(ie), .int_want(int_want)
    );

    assign rd_idx[0] = p_ptr;
    assign rd_idx[1] = x_ptr;
    assign rd_idx[2] = '0;
    assign rd_idx[3] = reg_i;

    regptr_file #(.NREG(NREG), .AW(AW), .NRD(NRD)) u_file (
        .clk(clk), .rst_n(rst_n), .we(we), .wr_idx(wr_idx), .wr_val(wr_val),
        .rd_idx(rd_idx), .rd_val(rd_val)
    );

    always_comb begin
        addr_o = '0;
        kind   = KIND_NONE;
        unique case (st)
            ST_FETCH: begin
                addr_o = rd_val[0];
                kind   = KIND_PROG;
            end
            ST_EXEC: begin
                if (cmd == CMD_IMM) begin
                    addr_o = rd_val[0];
                    kind   = KIND_PROG;
                end else if (cmd == CMD_MEMX) begin
                    addr_o = rd_val[1];
                    kind   = KIND_DATA;
                end
            end
            ST_DMA: begin
                addr_o = rd_val[2];
                kind   = KIND_DMA;
            end
            ST_INTR: ;
        endcase
        kind_o = kind;
    end

    always_comb begin
        we     = 1'b0;
        wr_idx = p_ptr;
        wr_val = rd_val[0] + 1'b1;
        if (last) begin
            unique case (st)
                ST_FETCH: we = 1'b1;
                ST_DMA: begin
                    we     = 1'b1;
                    wr_idx = '0;
                    wr_val = rd_val[2] + 1'b1;
                end
                ST_EXEC: begin
                    case (cmd)
                        CMD_IMM: we = 1'b1;
                        CMD_LDLO: begin
                            we     = 1'b1;
                            wr_idx = reg_i;
                            wr_val = {rd_val[3][AW-1:DW], data_i};
                        end
                        CMD_LDHI: begin
                            we     = 1'b1;
                            wr_idx = reg_i;
                            wr_val = {data_i, rd_val[3][DW-1:0]};
                        end
                        CMD_INC: begin
                            we     = 1'b1;
                            wr_idx = reg_i;
                            wr_val = rd_val[3] + 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_INTR: ;
            endcase
        end
    end

endmodule

// File: rtl/regptr_bank_chk.sv
module regptr_bank_chk
    import regptr_pkg::*;
#(
    parameter int PW = 4,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input state_e        state,
    input logic          last,
    input logic          going_int,
    input logic [3:0]    cmd,
    input logic          dma_req,
    input logic          ie,
    input logic [PW-1:0] p_ptr,
    input logic [PW-1:0] x_ptr,
    input logic [2*PW-1:0] t_reg,
    input logic [AW-1:0] addr,
    input logic [1:0]    kind
);

    p_fetch_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (kind == KIND_PROG));

    p_cycle_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!last && state != ST_EXEC) |=> ($stable(addr) && $stable(kind)));

    p_int_force_r8: assert property (@(posedge clk) disable iff (!rst_n)
        going_int |=> (p_ptr == PW'(P_ON_INT) && x_ptr == PW'(X_ON_INT) && !ie));

    p_no_reentry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTR) |-> !ie);

    p_ret_restore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (last && state == ST_EXEC && cmd == CMD_RET && !going_int) |=>
        (p_ptr == $past(t_reg[2*PW-1:PW]) && x_ptr == $past(t_reg[PW-1:0]) && ie));

    p_dma_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (last && state != ST_FETCH && dma_req) |=> (state == ST_DMA));

    p_fetch_to_exec_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (last && state == ST_FETCH) |=> (state == ST_EXEC));

endmodule

bind regptr_bank regptr_bank_chk #(.PW(PW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(st), .last(last), .going_int(going_int),
    .cmd(cmd_i), .dma_req(dma_req_i), .ie(ie), .p_ptr(p_ptr), .x_ptr(x_ptr),
    .t_reg(t_reg), .addr(addr_o), .kind(kind_o)
);

// File: tb/regptr_bank_tb.sv
module regptr_bank_tb;

    localparam int TCLK = 10;
    localparam int CYC  = 8;
    localparam int MS_FETCH = 0, MS_EXEC = 1, MS_DMA = 2, MS_INTR = 3;
    localparam logic [3:0] C_NOP = 0, C_SETP = 1, C_SETX = 2, C_LDLO = 3,
        C_LDHI = 4, C_INC = 5, C_IMM = 6, C_MEMX = 7, C_RET = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_i = '0;
    logic [3:0]  reg_i = '0;
    logic [7:0]  data_i = '0;
    logic        irq_i = 1'b0;
    logic        dma_req_i = 1'b0;
    logic [15:0] addr_o;
    logic [1:0]  kind_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    string cur_tag = "R1";
    logic irq_lvl = 1'b0;

    logic [15:0] m_r [16];
    logic [3:0]  m_p, m_x;
    logic [7:0]  m_t;
    logic        m_ie, m_pend;
    int          m_st;

    always #(TCLK/2) clk = ~clk;

    regptr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .reg_i(reg_i), .data_i(data_i),
        .irq_i(irq_i), .dma_req_i(dma_req_i), .addr_o(addr_o), .kind_o(kind_o)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: addr/kind actual %h/%0d expected %h/%0d (cycle type %0d)",
                     tag, act[17:2], act[1:0], exp[17:2], exp[1:0], m_st);
        end
    endtask

    function automatic logic [17:0] exp_bus(input logic [3:0] c);
        case (m_st)
            MS_FETCH: return {m_r[m_p], 2'd1};
            MS_EXEC:  return (c == C_IMM) ? {m_r[m_p], 2'd1} :
                             (c == C_MEMX) ? {m_r[m_x], 2'd2} : 18'd0;
            MS_DMA:   return {m_r[0], 2'd3};
            default:  return 18'd0;
        endcase
    endfunction

    task automatic model_update(input logic [3:0] c, input logic [3:0] rg,
                                input logic [7:0] d, input logic dm, input logic irq);
        int nxt;
        logic want;
        want = m_ie && (irq || m_pend);
        case (m_st)
            MS_FETCH: m_r[m_p] = m_r[m_p] + 16'd1;
            MS_DMA:   m_r[0] = m_r[0] + 16'd1;
            MS_EXEC: begin
                case (c)
                    C_SETP: m_p = rg;
                    C_SETX: m_x = rg;
                    C_LDLO: m_r[rg][7:0] = d;
                    C_LDHI: m_r[rg][15:8] = d;
                    C_INC:  m_r[rg] = m_r[rg] + 16'd1;
                    C_IMM:  m_r[m_p] = m_r[m_p] + 16'd1;
                    C_RET: begin
                        m_p = m_t[7:4];
                        m_x = m_t[3:0];
                        m_ie = 1'b1;
                    end
                    default: ;
                endcase
            end
            default: ;
        endcase
        if (m_st == MS_FETCH) nxt = MS_EXEC;
        else if (dm) nxt = MS_DMA;
        else if (want) nxt = MS_INTR;
        else nxt = MS_FETCH;
        if (nxt == MS_INTR) begin
            m_t = {m_p, m_x};
            m_p = 4'd1;
            m_x = 4'd2;
            m_ie = 1'b0;
            m_pend = 1'b0;
        end else if (m_st != MS_INTR && irq) begin
            m_pend = 1'b1;
        end
        m_st = nxt;
    endtask

    task automatic run_cycle(input logic [3:0] c, input logic [3:0] rg,
                             input logic [7:0] d, input logic dm);
        logic [17:0] e;
        cmd_i = c; reg_i = rg; data_i = d; dma_req_i = dm; irq_i = irq_lvl;
        e = exp_bus(c);
        #1;
        check(cur_tag, {addr_o, kind_o}, e);
        repeat (CYC - 1) @(negedge clk);
        #1;
        check("R7", {addr_o, kind_o}, e);
        @(negedge clk);
        model_update(c, rg, d, dm, irq_lvl);
    endtask

    task automatic instr(input logic [3:0] c, input logic [3:0] rg,
                         input logic [7:0] d, input logic dm);
        bit was_exec;
        do begin
            was_exec = (m_st == MS_EXEC);
            run_cycle(c, rg, d, was_exec ? dm : 1'b0);
        end while (!was_exec);
    endtask

    initial begin
        #(TCLK * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1802_5eed));
        for (int i = 0; i < 16; i++) m_r[i] = 16'h0;
        m_p = 0; m_x = 0; m_t = 0; m_ie = 1; m_pend = 0; m_st = MS_FETCH;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: first cycle after reset fetches from R0 = 0
        cur_tag = "R1";
        instr(C_NOP, 0, 0, 0);
        cur_tag = "R2";
        repeat (3) instr(C_NOP, 0, 0, 0);

        // R5: load every register, then byte lanes and carry
        cur_tag = "R5";
        for (int i = 1; i < 16; i++) begin
            instr(C_LDLO, 4'(i), 8'($urandom), 0);
            instr(C_LDHI, 4'(i), 8'($urandom), 0);
        end
        instr(C_LDLO, 5, 8'hFF, 0);
        instr(C_LDHI, 5, 8'h00, 0);
        instr(C_INC, 5, 0, 0);
        instr(C_LDHI, 6, 8'hA5, 0);

        // R4: index register selection, no increment
        cur_tag = "R4";
        instr(C_SETX, 5, 0, 0);
        instr(C_MEMX, 0, 0, 0);
        instr(C_MEMX, 0, 0, 0);
        instr(C_SETX, 6, 0, 0);
        instr(C_MEMX, 0, 0, 0);

        // R3: switch program register and back
        cur_tag = "R3";
        instr(C_SETP, 3, 0, 0);
        repeat (2) instr(C_NOP, 0, 0, 0);
        instr(C_SETP, 0, 0, 0);
        instr(C_NOP, 0, 0, 0);

        // R6: inline operands
        cur_tag = "R6";
        instr(C_SETP, 3, 0, 0);
        instr(C_IMM, 0, 0, 0);
        instr(C_IMM, 0, 0, 0);
        instr(C_SETX, 5, 0, 0);

        // R8: interrupt entry; R9: held request while masked
        cur_tag = "R8";
        irq_lvl = 1'b1;
        instr(C_NOP, 0, 0, 0);
        instr(C_NOP, 0, 0, 0);
        cur_tag = "R9";
        repeat (3) instr(C_NOP, 0, 0, 0);
        instr(C_MEMX, 0, 0, 0);
        irq_lvl = 1'b0;

        // R10: return restores P=3, X=5
        cur_tag = "R10";
        instr(C_RET, 0, 0, 0);
        instr(C_NOP, 0, 0, 0);
        instr(C_MEMX, 0, 0, 0);

        // R11: pulse while masked is kept pending
        cur_tag = "R11";
        irq_lvl = 1'b1;
        instr(C_NOP, 0, 0, 0);
        irq_lvl = 1'b0;
        instr(C_NOP, 0, 0, 0);
        irq_lvl = 1'b1;
        instr(C_NOP, 0, 0, 0);
        irq_lvl = 1'b0;
        instr(C_RET, 0, 0, 0);
        repeat (2) instr(C_NOP, 0, 0, 0);
        instr(C_RET, 0, 0, 0);
        instr(C_NOP, 0, 0, 0);

        // R12: DMA through R0
        cur_tag = "R12";
        instr(C_NOP, 0, 0, 1);
        instr(C_NOP, 0, 0, 1);
        instr(C_NOP, 0, 0, 0);

        // R13: DMA beats a simultaneous interrupt
        cur_tag = "R13";
        irq_lvl = 1'b1;
        instr(C_NOP, 0, 0, 1);
        irq_lvl = 1'b0;
        instr(C_NOP, 0, 0, 0);
        instr(C_RET, 0, 0, 0);
        instr(C_NOP, 0, 0, 0);

        // random mix, checked against the model (R2 and all others)
        cur_tag = "R2";
        for (int n = 0; n < 600; n++) begin
            logic [3:0] c;
            int r;
            r = int'($urandom % 20);
            c = (r < 9) ? 4'(r) : C_NOP;
            if (($urandom % 10) == 0) irq_lvl = 1'($urandom);
            instr(c, 4'($urandom), 8'($urandom), (($urandom % 8) == 0));
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule